// File: doc/BRIEF.md
# Banked Memory Mapper Register File

This block holds the write-only control state of a cartridge-style memory mapper and turns it into bank numbers. The CPU writes into the upper half of its address space. The block reduces each such address to one of eight register targets: a bank-select byte, a bank-data port that loads the program or pattern bank register the select byte points at, a mirroring control, and three IRQ control targets. The CPU can also write a group of four outer registers, one after another, through one fixed address. These registers add an offset and a bit mask to every bank the block resolves.

The block has two translation paths, and each is a purely combinational lookup on the stored state. The program path takes CPU address bits 14:13 and returns the 8 KB bank for that window. The pattern path takes video address bits 12:10 and returns the 1 KB bank for that slot. Each resolved number is reduced modulo the ROM size set by a parameter, so the output always points inside the ROM. Two mode bits in the select byte exchange the contents of program windows 0 and 2, or of the two halves of the pattern slots. A register write therefore reaches the outputs in the cycle that follows the write edge.

Top module: `banked_mapper_regs`

## Requirements
- R1: After reset, bank registers, select byte, outer registers and outer index are zero, mirroring select is 0 and IRQ enable, counter and latch outputs are 0; windows 0-2 resolve to bank 0 and every pattern slot to bank 0.
- R2: A write with address bit 15 set is decoded on (address AND 0xE001), so aliases such as 0x9FFF act as 0x8001. Writes below 0x8000 other than to exactly 0x6000 change nothing, and the target 0xA001 has no effect.
- R3: With select index 0 (slots 0,1) or 1 (slots 2,3), a bank-data write stores the data with bit 0 cleared in the even slot and with bit 0 set in the odd slot.
- R4: Select indices 2,3,4,5 load the full data byte into pattern slots 4,5,6,7 respectively.
- R5: Select index 7 loads data[5:0] into program window 1. Select index 6 loads data[5:0] into window 0 when select bit 6 is 0, and into window 2 when it is 1.
- R6: A select-byte write whose bit 6 differs from the stored bit 6 exchanges the contents of program windows 0 and 2.
- R7: A select-byte write whose bit 7 differs from the stored bit 7 exchanges pattern slots 0-3 with slots 4-7. Later writes still address physical slots.
- R8: Program window 3 (CPU address bits 14:13 = 3) always resolves to bank PRG_BANKS-1.
- R9: A write decoded as 0xA000 sets the mirroring select to data bit 0. The select holds its value otherwise.
- R10: A write decoded as 0xC000 loads the IRQ counter value and one decoded as 0xC001 loads the IRQ latch value. A write decoded as 0xE000 clears IRQ enable and one decoded as 0xE001 sets it.
- R11: A write to 0x6000 stores the data in outer register[index], then the 2-bit index advances modulo 4. Outer 0 is ORed into program banks 0-2, outer 1 is ORed into pattern banks, outer 2 clears the pattern bits it has set, and outer 3 clears the program bits it has set. The mask is applied before the OR.
- R12: Resolved program banks are reduced modulo PRG_BANKS and pattern banks modulo CHR_BANKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_page | input | 2 | CPU address bits 14:13, program window |
| chr_page | input | 3 | Video address bits 12:10, pattern slot |
| prg_bank | output | PRG_W | Resolved 8 KB program bank |
| chr_bank | output | CHR_W | Resolved 1 KB pattern bank |
| mirror_sel | output | 1 | Mirroring mode select |
| irq_en | output | 1 | IRQ enable |
| irq_count | output | 8 | Stored IRQ counter load value |
| irq_latch | output | 8 | Stored IRQ latch value |

## Verification
Any corrupted bank register shows up on prg_bank or chr_bank in the cycle after the write, as soon as the window or slot that holds it is probed. A missed or doubled swap shows up as two windows, or two slot halves, that have traded places. An outer index that steps wrongly sends later outer data into the wrong offset or mask. That error stays hidden until the next round of outer writes, so the bench writes a fifth value and confirms that it lands back in outer register 0.

// File: rtl/banked_mapper_regs.sv
`timescale 1ns/1ps
module banked_mapper_regs #(
  parameter int PRG_BANKS = 24,
  parameter int CHR_BANKS = 200,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       prg_page,
  input  logic [2:0]       chr_page,
  output logic [PRG_W-1:0] prg_bank,
  output logic [CHR_W-1:0] chr_bank,
  output logic             mirror_sel,
  output logic             irq_en,
  output logic [7:0]       irq_count,
  output logic [7:0]       irq_latch
);
  localparam logic [PRG_W-1:0] LAST_PRG = PRG_W'(PRG_BANKS - 1);

  logic [1:0] mode_q;
  logic [2:0] idx_q;
  logic [5:0] prg_q [3];
  logic [7:0] chr_q [8];
  logic [7:0] outer_q [4];
  logic [1:0] outer_idx;

  wire [15:0] reg_key  = wr_addr & 16'hE001;
  wire        reg_wr   = wr_en & wr_addr[15];
  wire        outer_wr = wr_en && (wr_addr == 16'h6000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      idx_q      <= '0;
      mirror_sel <= 1'b0;
      irq_en     <= 1'b0;
      irq_count  <= '0;
      irq_latch  <= '0;
      outer_idx  <= '0;
      for (int i = 0; i < 3; i++) prg_q[i] <= '0;
      for (int i = 0; i < 8; i++) chr_q[i] <= '0;
      for (int i = 0; i < 4; i++) outer_q[i] <= '0;
    end else begin
      if (outer_wr) begin
        outer_q[outer_idx] <= wr_data;
        outer_idx          <= outer_idx + 2'd1;
      end
      if (reg_wr) begin
        case (reg_key)
          16'h8000: begin
            if (wr_data[6] != mode_q[0]) begin
              prg_q[0] <= prg_q[2];
              prg_q[2] <= prg_q[0];
            end
            if (wr_data[7] != mode_q[1]) begin
              for (int i = 0; i < 4; i++) begin
                chr_q[i]     <= chr_q[i + 4];
                chr_q[i + 4] <= chr_q[i];
              end
            end
            mode_q <= wr_data[7:6];
            idx_q  <= wr_data[2:0];
          end
          16'h8001: begin
            case (idx_q)
              3'd0, 3'd1: begin
                chr_q[{1'b0, idx_q[0], 1'b0}] <= {wr_data[7:1], 1'b0};
                chr_q[{1'b0, idx_q[0], 1'b1}] <= {wr_data[7:1], 1'b1};
              end
              3'd6: begin
                if (mode_q[0]) prg_q[2] <= wr_data[5:0];
                else           prg_q[0] <= wr_data[5:0];
              end
              3'd7:    prg_q[1] <= wr_data[5:0];
              default: chr_q[idx_q + 3'd2] <= wr_data;
            endcase
          end
          16'hA000: mirror_sel <= wr_data[0];
          16'hC000: irq_count  <= wr_data;
          16'hC001: irq_latch  <= wr_data;
          16'hE000: irq_en     <= 1'b0;
          16'hE001: irq_en     <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  logic [5:0] prg_raw;
  always_comb begin
    case (prg_page)
      2'd0:    prg_raw = prg_q[0];
      2'd1:    prg_raw = prg_q[1];
      default: prg_raw = prg_q[2];
    endcase
  end

  wire [7:0] prg_mix = ({2'b00, prg_raw} & ~outer_q[3]) | outer_q[0];
  wire [7:0] chr_mix = (chr_q[chr_page] & ~outer_q[2]) | outer_q[1];

  assign prg_bank = (prg_page == 2'd3) ? LAST_PRG
                                       : PRG_W'(32'(prg_mix) % PRG_BANKS);
  assign chr_bank = CHR_W'(32'(chr_mix) % CHR_BANKS);
endmodule

// File: rtl/mapper_regs_chk.sv
`timescale 1ns/1ps
module mapper_regs_chk #(
  parameter int PRG_BANKS = 24,
  parameter int CHR_BANKS = 200,
  localparam int PRG_W = $clog2(PRG_BANKS),
  localparam int CHR_W = $clog2(CHR_BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [15:0]      wr_addr,
  input logic [7:0]       wr_data,
  input logic [1:0]       prg_page,
  input logic [PRG_W-1:0] prg_bank,
  input logic [CHR_W-1:0] chr_bank,
  input logic             mirror_sel,
  input logic             irq_en,
  input logic [1:0]       outer_idx
);
  wire        hi  = wr_en & wr_addr[15];
  wire [15:0] key = wr_addr & 16'hE001;

  a_r9_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && key == 16'hA000) |=> (mirror_sel == $past(wr_data[0])));

  a_r9_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && key == 16'hA000) |=> $stable(mirror_sel));

  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && key == 16'hE001) |=> irq_en);

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && key == 16'hE000) |=> !irq_en);

  a_r11_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 16'h6000) |=> (outer_idx == $past(outer_idx) + 2'd1));

  a_r11_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 16'h6000) |=> $stable(outer_idx));

  a_r8_last_window: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_page == 2'd3) |-> (prg_bank == PRG_W'(PRG_BANKS - 1)));

  a_r12_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(prg_bank) < PRG_BANKS) && (32'(chr_bank) < CHR_BANKS));
endmodule

bind banked_mapper_regs mapper_regs_chk #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .prg_page(prg_page), .prg_bank(prg_bank), .chr_bank(chr_bank),
  .mirror_sel(mirror_sel), .irq_en(irq_en), .outer_idx(outer_idx)
);

// File: tb/sim_banked_mapper_regs.sv
`timescale 1ns/1ps
module sim_banked_mapper_regs;
  localparam int PB = 24;
  localparam int CB = 200;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  prg_page = '0;
  logic [2:0]  chr_page = '0;
  logic [4:0]  prg_bank;
  logic [7:0]  chr_bank;
  logic mirror_sel, irq_en;
  logic [7:0] irq_count, irq_latch;

  banked_mapper_regs #(.PRG_BANKS(PB), .CHR_BANKS(CB)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prg_page(prg_page), .chr_page(chr_page), .prg_bank(prg_bank), .chr_bank(chr_bank),
    .mirror_sel(mirror_sel), .irq_en(irq_en), .irq_count(irq_count), .irq_latch(irq_latch)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int prg_m [3];
  int chr_m [8];
  int o [4];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int prg_exp(int w);
    if (w == 3) return PB - 1;
    return ((prg_m[w] & ~o[3] & 255) | o[0]) % PB;
  endfunction

  function automatic int chr_exp(int s);
    return ((chr_m[s] & ~o[2] & 255) | o[1]) % CB;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_banks(string tag);
    for (int w = 0; w < 4; w++) begin
      prg_page = 2'(w); #1;
      chk({tag, " prg window"}, int'(prg_bank), prg_exp(w));
    end
    for (int s = 0; s < 8; s++) begin
      chr_page = 3'(s); #1;
      chk({tag, " chr slot"}, int'(chr_bank), chr_exp(s));
    end
  endtask

  task automatic swap_chr();
    for (int i = 0; i < 4; i++) begin
      int t = chr_m[i]; chr_m[i] = chr_m[i + 4]; chr_m[i + 4] = t;
    end
  endtask

  task automatic t_reset();
    foreach (prg_m[i]) prg_m[i] = 0;
    foreach (chr_m[i]) chr_m[i] = 0;
    foreach (o[i]) o[i] = 0;
    check_banks("R1 reset");
    chk("R1 mirror", mirror_sel, 0);
    chk("R1 irq_en", irq_en, 0);
    chk("R1 irq_count", irq_count, 0);
    chk("R1 irq_latch", irq_latch, 0);
  endtask

  task automatic t_pairs();
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h37);
    chr_m[0] = 8'h36; chr_m[1] = 8'h37;
    wr(16'h8000, 8'h01); wr(16'h8001, 8'h81);
    chr_m[2] = 8'h80; chr_m[3] = 8'h81;
    check_banks("R3 pair");
  endtask

  task automatic t_singles();
    for (int i = 2; i < 6; i++) begin
      wr(16'h8000, 8'(i)); wr(16'h8001, 8'(8'h10 + i));
      chr_m[i + 2] = 8'h10 + i;
    end
    check_banks("R4 single");
  endtask

  task automatic t_modulo();
    wr(16'h8000, 8'h00); wr(16'h8001, 8'hC9);
    chr_m[0] = 8'hC8; chr_m[1] = 8'hC9;
    chr_page = 3'd0; #1; chk("R12 chr 200 wraps", chr_bank, 0);
    chr_page = 3'd1; #1; chk("R12 chr 201 wraps", chr_bank, 1);
  endtask

  task automatic t_prg();
    wr(16'h8000, 8'h06); wr(16'h8001, 8'hFF);
    prg_m[0] = 63;
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h05);
    prg_m[1] = 5;
    prg_page = 2'd0; #1; chk("R5 R12 window0 63 mod 24", prg_bank, 15);
    prg_page = 2'd3; #1; chk("R8 last window", prg_bank, PB - 1);
    check_banks("R5 prg");
  endtask

  task automatic t_prg_swap();
    wr(16'h8000, 8'h46);
    prg_m[2] = prg_m[0]; prg_m[0] = 0;
    check_banks("R6 swap on");
    wr(16'h8001, 8'h09);
    prg_m[2] = 9;
    check_banks("R5 select6 to window2");
    wr(16'h8000, 8'h06);
    prg_m[0] = 9; prg_m[2] = 0;
    check_banks("R6 swap off");
  endtask

  task automatic t_chr_swap();
    wr(16'h8000, 8'h80); swap_chr();
    check_banks("R7 halves swapped");
    wr(16'h8000, 8'h82); wr(16'h8001, 8'h55);
    chr_m[4] = 8'h55;
    check_banks("R7 physical slot write");
    wr(16'h8000, 8'h02); swap_chr();
    check_banks("R7 halves restored");
  endtask

  task automatic t_decode();
    wr(16'hBFFE, 8'h01);
    chk("R2 R9 alias A000 sets mirror", mirror_sel, 1);
    wr(16'hA001, 8'h00);
    chk("R2 A001 no effect", mirror_sel, 1);
    wr(16'hA000, 8'hFE);
    chk("R9 mirror from bit0", mirror_sel, 0);
    wr(16'h7000, 8'hFF); wr(16'h6001, 8'hFF); wr(16'h0000, 8'hFF);
    check_banks("R2 low writes ignored");
    chk("R2 mirror after low writes", mirror_sel, 0);
    wr(16'h9FFE, 8'h07); wr(16'h9FFF, 8'h0B);
    prg_m[1] = 11;
    check_banks("R2 alias 8001");
  endtask

  task automatic t_irq();
    wr(16'hDFFE, 8'h44);
    chk("R10 counter", irq_count, 8'h44);
    wr(16'hC001, 8'h99);
    chk("R10 latch", irq_latch, 8'h99);
    chk("R10 counter kept", irq_count, 8'h44);
    wr(16'hE001, 8'h00);
    chk("R10 enable set", irq_en, 1);
    wr(16'hFFFE, 8'hFF);
    chk("R10 enable cleared", irq_en, 0);
  endtask

  task automatic t_outer();
    wr(16'h6000, 8'h02); o[0] = 2;
    check_banks("R11 outer0");
    wr(16'h6000, 8'h80); o[1] = 8'h80;
    wr(16'h6000, 8'h0F); o[2] = 8'h0F;
    wr(16'h6000, 8'h01); o[3] = 8'h01;
    check_banks("R11 R12 outer all");
    wr(16'h6000, 8'h00); o[0] = 0;
    check_banks("R11 index wraps");
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pairs();
    t_singles();
    t_modulo();
    t_prg();
    t_prg_swap();
    t_chr_swap();
    t_decode();
    t_irq();
    t_outer();
    done = 1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end
endmodule